// File: doc/BRIEF.md
# DLL Lock State Classifier

This block gives a delay-locked loop a coarse view of its lock state. Each delay-line tap clocks its own flip-flop, which records the level of the reference clock at that tap's rising edge. A feedback-stage select picks three of those samples. The resulting 3-bit code is mapped to one of three mutually exclusive states, and the state is registered on the rising edge of the reference clock. The states are: delay too long (upper), delay near one reference period (active), and delay too short (lower).

The loop uses the state to steer its charge pump. Upper forces the UP request. Lower forces the DOWN request. In the active state, the UP and DOWN requests of the fine phase detector pass through unchanged. Two override inputs come from the feedback-switching logic, so that a change of feedback stage does not cause a wrong correction. One override forces upper. The other forces lower.

Top module: `dll_lock_classifier`

## Requirements
- R1: The flip-flop of each tap stage k (bit k-1 of `tap_clk`) captures the level of `ref_clk` on the rising edge of that tap and holds it until that tap's next rising edge. Asynchronous reset clears every sample to 0.
- R2: For feedback stage 7 or 8, the code {s1,s2,s3} is built from the samples of stages 2, 4 and 6, with s1 taken from the lowest stage. Stages 7 and 8 select the same taps.
- R3: For feedback stage 5 or 6, the code is built from the samples of stages 2, 3 and 4.
- R4: For any feedback stage of 4 or below, the code is built from the samples of stages 1, 2 and 3.
- R5: Codes 110 and 100 decode to active.
- R6: Code 111 decodes to lower.
- R7: Every other code decodes to upper. This includes any code with s1 = 0, and code 101.
- R8: When `force_upper` is 1 at a `ref_clk` rising edge, the state becomes upper, whatever the code and `force_lower` are.
- R9: When `force_lower` is 1 and `force_upper` is 0 at a `ref_clk` rising edge, the state becomes lower, whatever the code is.
- R10: Exactly one of `st_upper`, `st_active` and `st_lower` is 1 at all times.
- R11: While `rst_n` is 0, the state is upper.
- R12: `up_out` is 1 in the upper state. `dn_out` is 1 in the lower state. In the active state, `up_out` follows `pd_up` and `dn_out` follows `pd_dn`. No other combination asserts either output.
- R13: The state changes only on a `ref_clk` rising edge. New tap edges and input changes between two such edges leave the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; data for the tap samplers and clock of the state register |
| rst_n | input | 1 | Asynchronous active-low reset |
| tap_clk | input | N_STAGES | Delay-line tap outputs; bit k-1 is stage k |
| fb_stage | input | SEL_W | Feedback stage number (1..N_STAGES) |
| force_upper | input | 1 | Override request: force the upper state |
| force_lower | input | 1 | Override request: force the lower state |
| pd_up | input | 1 | UP request from the fine phase detector |
| pd_dn | input | 1 | DOWN request from the fine phase detector |
| st_upper | output | 1 | State flag: delay too long |
| st_active | output | 1 | State flag: delay near one period |
| st_lower | output | 1 | State flag: delay too short |
| up_out | output | 1 | Charge-pump UP request |
| dn_out | output | 1 | Charge-pump DOWN request |

## Verification
The bench sweeps every feedback stage from 1 to 8 against all 256 patterns of tap sample levels. Each tap pattern is produced by pulsing the tap while the reference is high or low. Because of this, a wrong tap choice for any stage group shows up as a wrong state on some pattern, and so does a wrong decode of any of the eight codes. Every combination is repeated under all four override settings with varying phase-detector requests, which separates override priority from the pass-through of the active state. Before each reference edge, the flags are compared against the previous state to expose any path that bypasses the register.

// File: rtl/dll_lock_pkg.sv
`timescale 1ns/1ps
package dll_lock_pkg;

  typedef enum logic [2:0] {
    ST_UPPER  = 3'b100,
    ST_ACTIVE = 3'b010,
    ST_LOWER  = 3'b001
  } lock_state_t;

  // Stage number (1-based) sampled for code position k (0 = s1) given feedback stage fb.
  function automatic int tap_for(input int fb, input int k);
    int stage;
    if (fb >= 7) begin
      case (k)
        0:       stage = 2;
        1:       stage = 4;
        default: stage = 6;
      endcase
    end else if (fb >= 5) begin
      case (k)
        0:       stage = 2;
        1:       stage = 3;
        default: stage = 4;
      endcase
    end else begin
      case (k)
        0:       stage = 1;
        1:       stage = 2;
        default: stage = 3;
      endcase
    end
    return stage;
  endfunction

  // Map a sample code {s1,s2,s3} to a lock state.
  function automatic lock_state_t classify(input logic [2:0] code);
    lock_state_t st;
    case (code)
      3'b110, 3'b100: st = ST_ACTIVE;
      3'b111:         st = ST_LOWER;
      default:        st = ST_UPPER;
    endcase
    return st;
  endfunction

  // Apply override requests on top of the decoded state; upper request wins.
  function automatic lock_state_t resolve(input logic [2:0] code,
                                          input logic fu, input logic fl);
    lock_state_t st;
    if (fu)      st = ST_UPPER;
    else if (fl) st = ST_LOWER;
    else         st = classify(code);
    return st;
  endfunction

endpackage

// File: rtl/dll_tap_sampler.sv
`timescale 1ns/1ps
module dll_tap_sampler #(
  parameter int N_STAGES = 8
) (
  input  logic                ref_clk,
  input  logic                rst_n,
  input  logic [N_STAGES-1:0] tap_clk,
  output logic [N_STAGES-1:0] tap_q
);

  // One flip-flop per tap, each in its own clock domain, data = reference level.
  for (genvar g = 0; g < N_STAGES; g++) begin : g_tap
    logic q;
    always_ff @(posedge tap_clk[g] or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= ref_clk;
    end
    assign tap_q[g] = q;
  end

endmodule

// File: rtl/dll_tap_select.sv
`timescale 1ns/1ps
module dll_tap_select
  import dll_lock_pkg::*;
#(
  parameter int N_STAGES = 8,
  parameter int SEL_W    = 4,
  parameter int CODE_W   = 3
) (
  input  logic [N_STAGES-1:0] tap_q,
  input  logic [SEL_W-1:0]    fb_stage,
  output logic [CODE_W-1:0]   pick_code
);

  localparam int IDX_W = (N_STAGES > 1) ? $clog2(N_STAGES) : 1;

  always_comb begin
    pick_code = '0;
    for (int k = 0; k < CODE_W; k++) begin
      int stage;
      logic [IDX_W-1:0] idx;
      stage = tap_for(int'(fb_stage), k);
      idx   = IDX_W'(stage - 1);
      pick_code[CODE_W-1-k] = tap_q[idx];
    end
  end

endmodule

// File: rtl/dll_lock_state.sv
`timescale 1ns/1ps
module dll_lock_state
  import dll_lock_pkg::*;
(
  input  logic        ref_clk,
  input  logic        rst_n,
  input  logic [2:0]  pick_code,
  input  logic        force_upper,
  input  logic        force_lower,
  output lock_state_t state
);

  lock_state_t state_nx;

  always_comb state_nx = resolve(pick_code, force_upper, force_lower);

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) state <= ST_UPPER;
    else        state <= state_nx;
  end

endmodule

// File: rtl/dll_lock_classifier.sv
`timescale 1ns/1ps
module dll_lock_classifier
  import dll_lock_pkg::*;
#(
  parameter int N_STAGES = 8,
  parameter int SEL_W    = $clog2(N_STAGES + 1)
) (
  input  logic                ref_clk,
  input  logic                rst_n,
  input  logic [N_STAGES-1:0] tap_clk,
  input  logic [SEL_W-1:0]    fb_stage,
  input  logic                force_upper,
  input  logic                force_lower,
  input  logic                pd_up,
  input  logic                pd_dn,
  output logic                st_upper,
  output logic                st_active,
  output logic                st_lower,
  output logic                up_out,
  output logic                dn_out
);

  localparam int CODE_W = 3;

  logic [N_STAGES-1:0] tap_q;
  logic [CODE_W-1:0]   pick_code;
  lock_state_t         state;

  dll_tap_sampler #(.N_STAGES(N_STAGES)) u_sampler (
    .ref_clk (ref_clk),
    .rst_n   (rst_n),
    .tap_clk (tap_clk),
    .tap_q   (tap_q)
  );

  dll_tap_select #(.N_STAGES(N_STAGES), .SEL_W(SEL_W), .CODE_W(CODE_W)) u_select (
    .tap_q     (tap_q),
    .fb_stage  (fb_stage),
    .pick_code (pick_code)
  );

  dll_lock_state u_state (
    .ref_clk     (ref_clk),
    .rst_n       (rst_n),
    .pick_code   (pick_code),
    .force_upper (force_upper),
    .force_lower (force_lower),
    .state       (state)
  );

  assign st_upper  = state[2];
  assign st_active = state[1];
  assign st_lower  = state[0];

  assign up_out = st_upper | (st_active & pd_up);
  assign dn_out = st_lower | (st_active & pd_dn);

endmodule

// File: rtl/dll_lock_classifier_chk.sv
`timescale 1ns/1ps
module dll_lock_classifier_chk (
  input logic       ref_clk,
  input logic       rst_n,
  input logic [2:0] pick_code,
  input logic       force_upper,
  input logic       force_lower,
  input logic       pd_up,
  input logic       pd_dn,
  input logic       st_upper,
  input logic       st_active,
  input logic       st_lower,
  input logic       up_out,
  input logic       dn_out
);

  a_r10_one_flag: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $onehot({st_upper, st_active, st_lower}));

  a_r8_force_upper: assert property (@(posedge ref_clk) disable iff (!rst_n)
    force_upper |=> st_upper);

  a_r9_force_lower: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (force_lower && !force_upper) |=> st_lower);

  a_r6_all_high_lower: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (!force_upper && !force_lower && pick_code == 3'b111) |=> st_lower);

  a_r7_first_low_upper: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (!force_lower && !pick_code[2]) |=> st_upper);

  a_r12_up_path: assert property (@(posedge ref_clk) disable iff (!rst_n)
    st_upper |-> (up_out && !dn_out));

  a_r12_dn_path: assert property (@(posedge ref_clk) disable iff (!rst_n)
    st_lower |-> (dn_out && !up_out));

  a_r12_active_pass: assert property (@(posedge ref_clk) disable iff (!rst_n)
    st_active |-> (up_out == pd_up && dn_out == pd_dn));

endmodule

bind dll_lock_classifier dll_lock_classifier_chk u_chk (
  .ref_clk     (ref_clk),
  .rst_n       (rst_n),
  .pick_code   (pick_code),
  .force_upper (force_upper),
  .force_lower (force_lower),
  .pd_up       (pd_up),
  .pd_dn       (pd_dn),
  .st_upper    (st_upper),
  .st_active   (st_active),
  .st_lower    (st_lower),
  .up_out      (up_out),
  .dn_out      (dn_out)
);

// File: tb/dll_lock_classifier_bench.sv
`timescale 1ns/1ps
module dll_lock_classifier_bench;

  localparam int N = 8;
  localparam int SW = 4;

  logic          ref_clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  tap_clk = '0;
  logic [SW-1:0] fb_stage = 4'd8;
  logic          force_upper = 1'b0, force_lower = 1'b0, pd_up = 1'b0, pd_dn = 1'b0;
  logic          st_upper, st_active, st_lower, up_out, dn_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [2:0] prev_flags;

  dll_lock_classifier #(.N_STAGES(N)) u_dll_lock_classifier (
    .ref_clk(ref_clk), .rst_n(rst_n), .tap_clk(tap_clk), .fb_stage(fb_stage),
    .force_upper(force_upper), .force_lower(force_lower), .pd_up(pd_up), .pd_dn(pd_dn),
    .st_upper(st_upper), .st_active(st_active), .st_lower(st_lower),
    .up_out(up_out), .dn_out(dn_out)
  );

  always #10 ref_clk = ~ref_clk;  // 50 MHz

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Expected code: taps start at stage 1 for fb<=4, else stage 2; stride 2 for fb>=7.
  function automatic logic [2:0] exp_code(input int fb, input logic [N-1:0] pat);
    int base = (fb >= 5) ? 2 : 1;
    int step = (fb >= 7) ? 2 : 1;
    logic [2:0] c;
    for (int k = 0; k < 3; k++) c[2-k] = pat[base + k*step - 1];
    return c;
  endfunction

  // Flags {upper,active,lower}: active when s1=1 and s3=0; lower when all ones.
  function automatic logic [2:0] exp_flags(input logic [2:0] c, input logic fu, input logic fl);
    if (fu) return 3'b100;
    if (fl) return 3'b001;
    if (&c) return 3'b001;
    if (c[2] && !c[0]) return 3'b010;
    return 3'b100;
  endfunction

  task automatic run_case(input int fb, input logic [N-1:0] pat,
                          input logic fu, input logic fl, input logic pu, input logic pdn);
    logic [2:0] code, ef, af;
    logic eu, ed;
    @(posedge ref_clk); #2;
    tap_clk = pat;            // taps wanting 1 sample while reference is high (R1)
    #2 tap_clk = '0;
    @(negedge ref_clk); #2;
    tap_clk = ~pat;           // taps wanting 0 sample while reference is low
    #2 tap_clk = '0;
    #1;
    fb_stage = SW'(fb); force_upper = fu; force_lower = fl; pd_up = pu; pd_dn = pdn;
    af = {st_upper, st_active, st_lower};
    check(af == prev_flags, "R13 hold between edges", int'(af), int'(prev_flags));
    @(posedge ref_clk); #1;
    code = exp_code(fb, pat);
    ef = exp_flags(code, fu, fl);
    af = {st_upper, st_active, st_lower};
    if (fu)                     check(af == ef, "R8 force upper", int'(af), int'(ef));
    else if (fl)                check(af == ef, "R9 force lower", int'(af), int'(ef));
    else if (fb >= 7)           check(af == ef, "R2 taps 2/4/6 decode", int'(af), int'(ef));
    else if (fb >= 5)           check(af == ef, "R3 taps 2/3/4 decode", int'(af), int'(ef));
    else                        check(af == ef, "R4 taps 1/2/3 decode", int'(af), int'(ef));
    if (!fu && !fl) begin
      if (ef == 3'b010)      check(af == ef, "R5 active code", int'(af), int'(ef));
      else if (ef == 3'b001) check(af == ef, "R6 lower code", int'(af), int'(ef));
      else                   check(af == ef, "R7 upper code", int'(af), int'(ef));
    end
    check($countones(af) == 1, "R10 one flag", int'(af), 1);
    eu = ef[2] | (ef[1] & pu);
    ed = ef[0] | (ef[1] & pdn);
    check({up_out, dn_out} == {eu, ed}, "R12 up/dn", int'({up_out, dn_out}), int'({eu, ed}));
    prev_flags = ef;
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #25;
    check({st_upper, st_active, st_lower} == 3'b100, "R11 reset state",
          int'({st_upper, st_active, st_lower}), 4);
    check(up_out && !dn_out, "R12 reset up", int'({up_out, dn_out}), 2);
    @(negedge ref_clk); rst_n = 1'b1;
    prev_flags = 3'b100;
    // R1: after reset all samples are 0 -> code 000 -> upper
    @(posedge ref_clk); #1;
    check(st_upper == 1'b1, "R1 cleared samples give upper", int'(st_upper), 1);

    for (int fb = 1; fb <= 8; fb++)
      for (int p = 0; p < 256; p++)
        for (int ov = 0; ov < 4; ov++)
          run_case(fb, N'(p), ov[1], ov[0], p[0] ^ fb[0], p[7] ^ ov[0]);

    // Stages 7 and 8 must pick the same taps (R2)
    for (int p = 0; p < 256; p += 37) begin
      logic [2:0] a7;
      run_case(7, N'(p), 1'b0, 1'b0, 1'b0, 1'b0);
      a7 = {st_upper, st_active, st_lower};
      run_case(8, N'(p), 1'b0, 1'b0, 1'b0, 1'b0);
      check(a7 == {st_upper, st_active, st_lower}, "R2 stage 7 equals stage 8",
            int'(a7), int'({st_upper, st_active, st_lower}));
    end

    // Put the state in lower, then assert reset asynchronously (R11)
    run_case(8, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge ref_clk); #3 rst_n = 1'b0; #1;
    check({st_upper, st_active, st_lower} == 3'b100, "R11 async reset to upper",
          int'({st_upper, st_active, st_lower}), 4);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule